// File: doc/BRIEF.md
# RS-FEC symbol error rate monitor

This block sits behind a two-lane Reed-Solomon FEC decoder on the receive side. It turns the decoder's per-cycle results into statistics and a health flag. The inputs are a codeword-done strobe, a corrected-codeword pulse, an uncorrected-codeword pulse and a 3-bit symbol-error increment for each lane. The block echoes each accepted event as a single-cycle increment pulse and keeps saturating running totals. It also counts symbol errors, both lanes summed, over windows of 8192 decoded codewords. At each window boundary it raises or drops a high symbol-error-rate flag.

Four mode inputs are captured once, on the first clock after reset is released, and then held until the next reset:
- FEC enable
- correction enable
- indication enable
- strict-conformance mode

From these the block decides whether the whole function is bypassed or only the decoder is bypassed. While either bypass holds, all decoder strobes are ignored. The flag can only be raised while error indication is turned off.

Top module: `fec_ser_monitor`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied, the following all read 0: every pulse output, every running total, `hiSer` and `decoderBypassed`. At the same time `fecBypassed` reads 1.
- R2: The four mode inputs are captured on the first rising edge at which `rst` is low. Changes after that have no effect until the next reset.
- R3: If the captured FEC enable is 0, `fecBypassed` is 1. In that case every strobe is ignored: pulses stay 0 and totals stay at 0.
- R4: If FEC enable is 1, and strict-conformance, correction enable and indication enable are all 0, `decoderBypassed` is 1 and every strobe is ignored. If strict-conformance is 1, the decoder is never bypassed.
- R5: An accepted corrected or uncorrected codeword strobe gives a one-cycle pulse on `corrPulse` or `uncorrPulse` on the next cycle.
- R6: In an accepted cycle, the increment of lane i (bits [3i+2:3i] of `symErrInc`) appears on the same bits of `laneErrPulse` on the next cycle. In all other cycles `laneErrPulse` is 0.
- R7: The running totals work as follows. `corrTotal` and `uncorrTotal` each add 1 per accepted pulse. Lane i of `laneErrTotal` (bits [CNT_W*(i+1)-1:CNT_W*i]) adds that lane's accepted increment. Every total sticks at all ones instead of wrapping.
- R8: A window closes on the 8192nd accepted codeword-done strobe. Its count includes the increments of every accepted cycle since the previous boundary, including the closing cycle. `hiSer` takes its new value on the cycle after the closing strobe. It then keeps that value until the next boundary.
- R9: At a boundary `hiSer` becomes 1 only if the window's count is strictly above 417. A count of 417 gives 0 and a count of 418 gives 1.
- R10: If the captured indication enable is 1, `hiSer` stays 0 for any error count.
- R11: The window count saturates instead of wrapping, so a window with far more errors than the threshold still sets `hiSer`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgFecEn | input | 1 | FEC enable mode input, captured after reset |
| cfgCorrEn | input | 1 | Correction enable mode input, captured after reset |
| cfgIndEn | input | 1 | Error indication enable mode input, captured after reset |
| cfgStrict | input | 1 | Strict-conformance mode input, captured after reset |
| cwDone | input | 1 | One decoded codeword finished this cycle |
| cwCorrected | input | 1 | Codeword corrected strobe |
| cwUncorrected | input | 1 | Codeword uncorrectable strobe |
| symErrInc | input | LANES*INC_W | Per-lane symbol-error increments, lane i at [INC_W*i +: INC_W] |
| corrPulse | output | 1 | Corrected-codeword increment pulse |
| uncorrPulse | output | 1 | Uncorrected-codeword increment pulse |
| laneErrPulse | output | LANES*INC_W | Per-lane symbol-error increment pulses |
| corrTotal | output | CNT_W | Saturating corrected-codeword total |
| uncorrTotal | output | CNT_W | Saturating uncorrected-codeword total |
| laneErrTotal | output | LANES*CNT_W | Saturating per-lane symbol-error totals |
| hiSer | output | 1 | High symbol-error-rate flag |
| fecBypassed | output | 1 | Captured mode disables the whole FEC function |
| decoderBypassed | output | 1 | Captured mode bypasses the decoder |

## Verification
Pulses and running totals are due one cycle after the edge that accepts a strobe. `hiSer` is due one cycle after the edge that accepts the closing codeword-done of a window. The mode capture takes effect on the first edge after reset is released, so no strobe in that cycle counts. The bench keeps a behavioural model that steps on the same edges. It drives inputs on the falling edge and compares every output against the model there, half a cycle after each register update. It also makes explicit flag checks right after each window closes, with expected values fixed in advance.

// File: rtl/fec_ser_pkg.sv
package fec_ser_pkg;

  // Captured mode bits
  typedef struct packed {
    logic fecEn;
    logic corrEn;
    logic indEn;
    logic strict;
  } fec_mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;      // decoder results count this cycle
    logic winEnd;      // final codeword of a window accepted
    logic flagEnable;  // flag may be raised at this boundary
  } ser_ctl_t;

  typedef enum logic {ST_LOAD = 1'b0, ST_RUN = 1'b1} ctl_state_t;

endpackage

// File: rtl/fec_sat_counter.sv
module fec_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);

  logic [W:0] wideSum;

  assign wideSum = {1'b0, count} + (W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (en)
      count <= wideSum[W] ? '1 : wideSum[W-1:0];
  end

endmodule

// File: rtl/fec_ser_ctrl.sv
module fec_ser_ctrl
  import fec_ser_pkg::*;
#(
  parameter int WIN_CW = 8192
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgFecEn,
  input  logic     cfgCorrEn,
  input  logic     cfgIndEn,
  input  logic     cfgStrict,
  input  logic     cwDone,
  output ser_ctl_t ctlS,
  output logic     fecBypassed,
  output logic     decoderBypassed
);

  localparam int WIN_W = $clog2(WIN_CW + 1);
  localparam logic [WIN_W-1:0] LAST_CW = WIN_W'(WIN_CW - 1);

  ctl_state_t       state;
  fec_mode_t        mode;
  logic [WIN_W-1:0] winCnt;
  logic             decSkip;
  logic             live;
  logic             cwTick;
  logic             lastCw;

  // Mode capture: one load cycle after reset, then frozen
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD;
      mode  <= '0;
    end else if (state == ST_LOAD) begin
      mode  <= '{fecEn: cfgFecEn, corrEn: cfgCorrEn, indEn: cfgIndEn, strict: cfgStrict};
      state <= ST_RUN;
    end
  end

  assign decSkip = !mode.strict && !mode.corrEn && !mode.indEn;
  assign live    = (state == ST_RUN) && mode.fecEn && !decSkip;
  assign cwTick  = live && cwDone;
  assign lastCw  = (winCnt == LAST_CW);

  // Codeword window position
  always_ff @(posedge clk) begin
    if (rst)
      winCnt <= '0;
    else if (cwTick)
      winCnt <= lastCw ? '0 : winCnt + 1'b1;
  end

  always_comb begin
    ctlS.accept     = live;
    ctlS.winEnd     = cwTick && lastCw;
    ctlS.flagEnable = !mode.indEn;
  end

  assign fecBypassed     = !mode.fecEn;
  assign decoderBypassed = mode.fecEn && decSkip;

endmodule

// File: rtl/fec_ser_datapath.sv
module fec_ser_datapath
  import fec_ser_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int INC_W  = 3,
  parameter int CNT_W  = 32,
  parameter int THRESH = 417
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ser_ctl_t               ctlS,
  input  logic                   cwCorrected,
  input  logic                   cwUncorrected,
  input  logic [LANES*INC_W-1:0] symErrInc,
  output logic                   corrPulse,
  output logic                   uncorrPulse,
  output logic [LANES*INC_W-1:0] laneErrPulse,
  output logic [CNT_W-1:0]       corrTotal,
  output logic [CNT_W-1:0]       uncorrTotal,
  output logic [LANES*CNT_W-1:0] laneErrTotal,
  output logic                   hiSer
);

  localparam int ACC_W = $clog2(THRESH + 1) + 1;
  localparam int SUM_W = INC_W + $clog2(LANES + 1);
  localparam logic [ACC_W-1:0] THRESH_V = ACC_W'(THRESH);

  logic [SUM_W-1:0] laneSum;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accWide;
  logic [ACC_W-1:0] accNext;

  // Codeword event pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      corrPulse   <= 1'b0;
      uncorrPulse <= 1'b0;
    end else begin
      corrPulse   <= ctlS.accept && cwCorrected;
      uncorrPulse <= ctlS.accept && cwUncorrected;
    end
  end

  fec_sat_counter #(.W(CNT_W), .INC_W(1)) u_corrCnt (
    .clk(clk), .rst(rst), .en(ctlS.accept), .inc(cwCorrected), .count(corrTotal)
  );

  fec_sat_counter #(.W(CNT_W), .INC_W(1)) u_uncorrCnt (
    .clk(clk), .rst(rst), .en(ctlS.accept), .inc(cwUncorrected), .count(uncorrTotal)
  );

  // Per-lane echo and totals
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [INC_W-1:0] laneInc;
    assign laneInc = symErrInc[g*INC_W +: INC_W];

    always_ff @(posedge clk) begin
      if (rst)
        laneErrPulse[g*INC_W +: INC_W] <= '0;
      else
        laneErrPulse[g*INC_W +: INC_W] <= ctlS.accept ? laneInc : '0;
    end

    fec_sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_laneCnt (
      .clk(clk), .rst(rst), .en(ctlS.accept), .inc(laneInc),
      .count(laneErrTotal[g*CNT_W +: CNT_W])
    );
  end

  // Window symbol-error accumulator
  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++)
      laneSum = laneSum + SUM_W'(symErrInc[i*INC_W +: INC_W]);
  end

  assign accWide = {1'b0, acc} + (ACC_W+1)'(laneSum);
  assign accNext = accWide[ACC_W] ? '1 : accWide[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      hiSer <= 1'b0;
    end else if (ctlS.winEnd) begin
      acc   <= '0;
      hiSer <= ctlS.flagEnable && (accNext > THRESH_V);
    end else if (ctlS.accept) begin
      acc   <= accNext;
    end
  end

endmodule

// File: rtl/fec_ser_monitor.sv
module fec_ser_monitor
  import fec_ser_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int INC_W  = 3,
  parameter int CNT_W  = 32,
  parameter int WIN_CW = 8192,
  parameter int THRESH = 417
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfgFecEn,
  input  logic                   cfgCorrEn,
  input  logic                   cfgIndEn,
  input  logic                   cfgStrict,
  input  logic                   cwDone,
  input  logic                   cwCorrected,
  input  logic                   cwUncorrected,
  input  logic [LANES*INC_W-1:0] symErrInc,
  output logic                   corrPulse,
  output logic                   uncorrPulse,
  output logic [LANES*INC_W-1:0] laneErrPulse,
  output logic [CNT_W-1:0]       corrTotal,
  output logic [CNT_W-1:0]       uncorrTotal,
  output logic [LANES*CNT_W-1:0] laneErrTotal,
  output logic                   hiSer,
  output logic                   fecBypassed,
  output logic                   decoderBypassed
);

  ser_ctl_t ctlS;

  fec_ser_ctrl #(.WIN_CW(WIN_CW)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cfgFecEn       (cfgFecEn),
    .cfgCorrEn      (cfgCorrEn),
    .cfgIndEn       (cfgIndEn),
    .cfgStrict      (cfgStrict),
    .cwDone         (cwDone),
    .ctlS           (ctlS),
    .fecBypassed    (fecBypassed),
    .decoderBypassed(decoderBypassed)
  );

  fec_ser_datapath #(
    .LANES(LANES), .INC_W(INC_W), .CNT_W(CNT_W), .THRESH(THRESH)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctlS         (ctlS),
    .cwCorrected  (cwCorrected),
    .cwUncorrected(cwUncorrected),
    .symErrInc    (symErrInc),
    .corrPulse    (corrPulse),
    .uncorrPulse  (uncorrPulse),
    .laneErrPulse (laneErrPulse),
    .corrTotal    (corrTotal),
    .uncorrTotal  (uncorrTotal),
    .laneErrTotal (laneErrTotal),
    .hiSer        (hiSer)
  );

endmodule

// File: rtl/fec_ser_checker.sv
module fec_ser_checker
  import fec_ser_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INC_W = 3,
  parameter int CNT_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cwCorrected,
  input logic                   cwUncorrected,
  input logic [LANES*INC_W-1:0] symErrInc,
  input logic                   corrPulse,
  input logic                   uncorrPulse,
  input logic [LANES*INC_W-1:0] laneErrPulse,
  input logic [CNT_W-1:0]       corrTotal,
  input logic [CNT_W-1:0]       uncorrTotal,
  input logic                   hiSer,
  input logic                   fecBypassed,
  input logic                   decoderBypassed,
  input ser_ctl_t               ctlS
);

  p_corr_src_r5: assert property (@(posedge clk) disable iff (rst)
    corrPulse |-> $past(cwCorrected));

  p_uncorr_src_r5: assert property (@(posedge clk) disable iff (rst)
    uncorrPulse |-> $past(cwUncorrected));

  p_lane_echo_r6: assert property (@(posedge clk) disable iff (rst)
    (laneErrPulse != '0) |-> (laneErrPulse == $past(symErrInc)));

  p_fec_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (fecBypassed && $past(fecBypassed)) |-> (!corrPulse && !uncorrPulse && laneErrPulse == '0));

  p_dec_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (decoderBypassed && $past(decoderBypassed)) |-> (!corrPulse && !uncorrPulse && laneErrPulse == '0));

  p_corr_no_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (corrTotal >= $past(corrTotal)));

  p_uncorr_sticks_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (&$past(uncorrTotal))) |-> (&uncorrTotal));

  p_flag_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctlS.winEnd)) |-> $stable(hiSer));

  p_flag_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (ctlS.winEnd && !ctlS.flagEnable) |=> !hiSer);

endmodule

bind fec_ser_monitor fec_ser_checker #(
  .LANES(LANES), .INC_W(INC_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cwCorrected    (cwCorrected),
  .cwUncorrected  (cwUncorrected),
  .symErrInc      (symErrInc),
  .corrPulse      (corrPulse),
  .uncorrPulse    (uncorrPulse),
  .laneErrPulse   (laneErrPulse),
  .corrTotal      (corrTotal),
  .uncorrTotal    (uncorrTotal),
  .hiSer          (hiSer),
  .fecBypassed    (fecBypassed),
  .decoderBypassed(decoderBypassed),
  .ctlS           (ctlS)
);

// File: tb/fec_ser_monitor_bench.sv
`timescale 1ns/1ps
module fec_ser_monitor_bench;

  localparam int LN   = 2;
  localparam int IW   = 3;
  localparam int CW   = 10;
  localparam int WIN  = 8192;
  localparam int TH   = 417;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgFecEn = 0, cfgCorrEn = 0, cfgIndEn = 0, cfgStrict = 0;
  logic cwDone = 0, cwCorrected = 0, cwUncorrected = 0;
  logic [LN*IW-1:0] symErrInc = '0;

  logic             corrPulse, uncorrPulse, hiSer, fecBypassed, decoderBypassed;
  logic [LN*IW-1:0] laneErrPulse;
  logic [CW-1:0]    corrTotal, uncorrTotal;
  logic [LN*CW-1:0] laneErrTotal;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fec_ser_monitor #(.LANES(LN), .INC_W(IW), .CNT_W(CW), .WIN_CW(WIN), .THRESH(TH)) u_fec_ser_monitor (
    .clk(clk), .rst(rst),
    .cfgFecEn(cfgFecEn), .cfgCorrEn(cfgCorrEn), .cfgIndEn(cfgIndEn), .cfgStrict(cfgStrict),
    .cwDone(cwDone), .cwCorrected(cwCorrected), .cwUncorrected(cwUncorrected),
    .symErrInc(symErrInc),
    .corrPulse(corrPulse), .uncorrPulse(uncorrPulse), .laneErrPulse(laneErrPulse),
    .corrTotal(corrTotal), .uncorrTotal(uncorrTotal), .laneErrTotal(laneErrTotal),
    .hiSer(hiSer), .fecBypassed(fecBypassed), .decoderBypassed(decoderBypassed)
  );

  // Behavioural reference model
  bit mLoaded, mFec, mCorr, mInd, mStrict, mCorrP, mUncP, mHi;
  int mCorrT, mUncT, mWin, mAcc;
  int mLaneT[LN];
  int mLaneP[LN];

  function automatic int satAdd(int a, int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mLoaded = 0; mFec = 0; mCorr = 0; mInd = 0; mStrict = 0;
      mCorrP = 0; mUncP = 0; mHi = 0; mCorrT = 0; mUncT = 0; mWin = 0; mAcc = 0;
      foreach (mLaneT[i]) begin mLaneT[i] = 0; mLaneP[i] = 0; end
    end else if (!mLoaded) begin
      mFec = cfgFecEn; mCorr = cfgCorrEn; mInd = cfgIndEn; mStrict = cfgStrict;
      mLoaded = 1;
      mCorrP = 0; mUncP = 0;
      foreach (mLaneP[i]) mLaneP[i] = 0;
    end else begin
      bit act;
      act = mFec && (mStrict || mCorr || mInd);
      mCorrP = act && cwCorrected;
      mUncP  = act && cwUncorrected;
      foreach (mLaneP[i]) mLaneP[i] = act ? int'(symErrInc[i*IW +: IW]) : 0;
      if (act) begin
        mCorrT = satAdd(mCorrT, int'(cwCorrected));
        mUncT  = satAdd(mUncT, int'(cwUncorrected));
        foreach (mLaneT[i]) begin
          mLaneT[i] = satAdd(mLaneT[i], mLaneP[i]);
          mAcc = mAcc + mLaneP[i];
        end
        if (cwDone) begin
          mWin++;
          if (mWin == WIN) begin
            mHi = !mInd && (mAcc > TH);
            mWin = 0;
            mAcc = 0;
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R5 corrPulse", 64'(corrPulse), 64'(mCorrP));
    chk("R5 uncorrPulse", 64'(uncorrPulse), 64'(mUncP));
    for (int i = 0; i < LN; i++) begin
      chk("R6 laneErrPulse", 64'(laneErrPulse[i*IW +: IW]), 64'(mLaneP[i]));
      chk("R7 laneErrTotal", 64'(laneErrTotal[i*CW +: CW]), 64'(mLaneT[i]));
    end
    chk("R7 corrTotal", 64'(corrTotal), 64'(mCorrT));
    chk("R7 uncorrTotal", 64'(uncorrTotal), 64'(mUncT));
    chk("R8 hiSer", 64'(hiSer), 64'(mHi));
    chk("R3 fecBypassed", 64'(fecBypassed), 64'(!mFec));
    chk("R4 decoderBypassed", 64'(decoderBypassed), 64'(mFec && !mStrict && !mCorr && !mInd));
  endtask

  task automatic cyc(bit cd, bit cc, bit cu, int e0, int e1);
    @(negedge clk);
    compareAll();
    cwDone = cd; cwCorrected = cc; cwUncorrected = cu;
    symErrInc = {IW'(e1), IW'(e0)};
  endtask

  task automatic startMode(bit fe, bit ce, bit ie, bit st);
    @(negedge clk);
    rst = 1'b1;
    cwDone = 0; cwCorrected = 0; cwUncorrected = 0; symErrInc = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 corrTotal", 64'(corrTotal), 64'd0);
    chk("R1 laneErrTotal", 64'(laneErrTotal), 64'd0);
    chk("R1 hiSer", 64'(hiSer), 64'd0);
    chk("R1 pulses", 64'({corrPulse, uncorrPulse, laneErrPulse}), 64'd0);
    chk("R1 fecBypassed", 64'(fecBypassed), 64'd1);
    cfgFecEn = fe; cfgCorrEn = ce; cfgIndEn = ie; cfgStrict = st;
    rst = 1'b0;
    @(negedge clk);
    // R2: later changes are ignored
    cfgFecEn = ~fe; cfgCorrEn = ~ce; cfgIndEn = ~ie; cfgStrict = ~st;
  endtask

  task automatic runWindow(int errs, bit burst);
    int rem = errs;
    int done = 0;
    int i = 0;
    while (done < WIN) begin
      if (i % 2000 == 1999) begin
        cyc(0, 0, 0, 0, 0);
      end else begin
        int e0, e1;
        if (burst) begin
          e0 = 7; e1 = 7;
        end else begin
          e0 = (rem > 7) ? 7 : rem; rem -= e0;
          e1 = (rem > 5) ? 5 : rem; rem -= e1;
        end
        cyc(1, done % 5 == 0, done % 11 == 0, e0, e1);
        done++;
      end
      i++;
    end
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic strobeRun(int n);
    for (int k = 0; k < n; k++)
      cyc(1, k % 2 == 0, k % 3 == 0, k % 8, (k + 3) % 8);
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    // Correction on, indication off: flag active
    startMode(1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R2 fecBypassed after input change", 64'(fecBypassed), 64'd0);
    chk("R2 decoderBypassed after input change", 64'(decoderBypassed), 64'd0);
    runWindow(418, 0);
    chk("R9 418 errors sets hiSer", 64'(hiSer), 64'd1);
    runWindow(417, 0);
    chk("R9 417 errors clears hiSer", 64'(hiSer), 64'd0);
    runWindow(0, 1);
    chk("R11 saturated window sets hiSer", 64'(hiSer), 64'd1);
    chk("R7 lane0 total saturated", 64'(laneErrTotal[CW-1:0]), 64'(CMAX));
    chk("R7 lane1 total saturated", 64'(laneErrTotal[2*CW-1:CW]), 64'(CMAX));

    // Indication on: flag held low
    startMode(1, 1, 1, 1);
    runWindow(0, 1);
    chk("R10 indication on keeps hiSer low", 64'(hiSer), 64'd0);

    // Decoder bypass: strobes ignored
    startMode(1, 0, 0, 0);
    strobeRun(200);
    chk("R4 decoder bypass flagged", 64'(decoderBypassed), 64'd1);
    chk("R4 corrTotal untouched", 64'(corrTotal), 64'd0);
    chk("R4 laneErrTotal untouched", 64'(laneErrTotal), 64'd0);

    // FEC disabled: strobes ignored
    startMode(0, 1, 1, 1);
    strobeRun(200);
    chk("R3 fec bypass flagged", 64'(fecBypassed), 64'd1);
    chk("R3 uncorrTotal untouched", 64'(uncorrTotal), 64'd0);
    chk("R3 laneErrTotal untouched", 64'(laneErrTotal), 64'd0);

    // Strict mode keeps the decoder in path
    startMode(1, 0, 0, 1);
    runWindow(500, 0);
    chk("R4 strict mode not bypassed", 64'(decoderBypassed), 64'd0);
    chk("R8 window closes hiSer high", 64'(hiSer), 64'd1);
    for (int k = 0; k < 100; k++) cyc(0, 0, 0, 3, 4);
    cyc(0, 0, 0, 0, 0);
    chk("R8 hiSer holds between boundaries", 64'(hiSer), 64'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule